// File: doc/BRIEF.md
# Dual-Channel Receive Word Latch with Half-Word Readout

This block sits between two serial-word receiver cores and a 16-bit host data bus. Each receiver signals end of sequence with a one-cycle pulse and presents the 32-bit word it has just assembled. For each channel the block can optionally filter the word on a two-bit label field. If the word passes, the block stores it and pulls that channel's active-low ready flag low.

The host reads a stored word in two 16-bit halves. It raises that channel's read strobe for one cycle with the half-select input low for the lower half, and again with it high for the upper half. The halves may be read in either order. The ready flag returns high only once both halves have been read. A newer accepted word replaces an unread one without notice and restarts the half-read tracking.

Both channels share one bus output. An output-enable signal is provided so that the bus can be tri-stated outside the block.

Top module: `arinc_word_readout`

## Requirements
- R1: After reset, every `rdy_n` bit is 1, `bus_q` is 0, `bus_oe` is 0, and each stored word is 0.
- R2: An accepted end-of-sequence pulse on a channel stores that channel's `rx_word` slice and drives that channel's `rdy_n` to 0 from the following clock edge.
- R3: With `match_en` = 1, a word is accepted only when its bits [9:8] (counting from bit 0) equal that channel's two `match_bits`. A rejected word leaves the stored word and `rdy_n` unchanged.
- R4: With `match_en` = 0, every end-of-sequence pulse is accepted.
- R5: While a channel's strobe is granted, `bus_q` combinationally shows bits [15:0] of its stored word when `half_sel` = 0, and bits [31:16] when `half_sel` = 1.
- R6: `rdy_n` stays 0 until both halves have been read, in either order. It goes to 1 at the edge of the strobe that completes the pair. Reading the same half again does not complete the pair.
- R7: An accepted word that arrives before the pair is complete replaces the stored word and clears the half-read tracking, so both halves must be read again.
- R8: Strobes and arrivals on one channel never change the other channel's `rdy_n`.
- R9: When no strobe is active, `bus_q` is 0 and `bus_oe` is 0. When any strobe is active, `bus_oe` is 1.
- R10: When both strobes are active together, channel 0 drives the bus, and only channel 0's half-read tracking advances.
- R11: If an accepted arrival coincides with a read that would complete the pair on the same channel, the arrival wins: `rdy_n` stays 0 and the tracking is cleared.
- R12: Strobes on a channel whose `rdy_n` is 1 still drive the bus but do not change its tracking.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| eos | input | 2 | End-of-sequence pulse per channel |
| rx_word | input | 64 | Received words; channel c occupies bits [32c+31:32c] |
| match_en | input | 1 | Label filter enable |
| match_bits | input | 4 | Programmed label bits; channel c uses bits [2c+1:2c] |
| rd_stb | input | 2 | Read strobe per channel, active high |
| half_sel | input | 1 | 0 selects the lower half, 1 selects the upper half |
| rdy_n | output | 2 | Data-ready flag per channel, active low |
| bus_q | output | 16 | Shared host data output |
| bus_oe | output | 1 | Output enable for an external tri-state driver |

## Verification
The bus value and `bus_oe` are combinational from the strobes and the stored word. The bench drives the inputs after a falling edge and samples the bus 1 ns later, before the next rising edge. Storing a word, a change of `rdy_n` and a change of tracking all take effect one rising edge after the causing inputs. The bench therefore updates its model at that edge and compares `rdy_n` at the following falling edge. The effect of an overwrite on tracking is observed only through later `rdy_n` and bus values, never through internal state.

// File: rtl/rxl_pkg.sv
package rxl_pkg;
  localparam int WORD_W  = 32;
  localparam int HALF_W  = WORD_W / 2;
  localparam int LBL_LSB = 8;
  localparam int LBL_W   = 2;

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [HALF_W-1:0] half_t;
  typedef logic [LBL_W-1:0]  lbl_t;

  function automatic logic label_pass(input word_t w, input logic en, input lbl_t want);
    lbl_t got;
    got = w[LBL_LSB +: LBL_W];
    return !en || (got == want);
  endfunction

  function automatic half_t half_of(input word_t w, input logic upper);
    return upper ? w[HALF_W +: HALF_W] : w[0 +: HALF_W];
  endfunction
endpackage

// File: rtl/rxl_grant.sv
module rxl_grant #(
  parameter int NCH = 2
) (
  input  logic [NCH-1:0] req,
  output logic [NCH-1:0] gnt,
  output logic           any
);
  logic [NCH:0] blocked;

  assign blocked[0] = 1'b0;
  for (genvar c = 0; c < NCH; c++) begin : g_pri
    assign gnt[c]       = req[c] & ~blocked[c];
    assign blocked[c+1] = blocked[c] | req[c];
  end
  assign any = blocked[NCH];
endmodule

// File: rtl/rxl_chan.sv
module rxl_chan
  import rxl_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  eos,
  input  word_t word_in,
  input  logic  match_en,
  input  lbl_t  match_bits,
  input  logic  rd_grant,
  input  logic  half_sel,
  output word_t word_q,
  output logic  rdy_n,
  output logic  acc_evt,
  output logic  done_evt
);
  logic got_lo, got_hi;
  logic rd_live;

  assign acc_evt  = eos & label_pass(word_in, match_en, match_bits);
  assign rd_live  = rd_grant & ~rdy_n;
  assign done_evt = rd_live & ~acc_evt & (half_sel ? got_lo : got_hi);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      rdy_n  <= 1'b1;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (acc_evt) begin
      word_q <= word_in;
      rdy_n  <= 1'b0;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (done_evt) begin
      rdy_n  <= 1'b1;
      got_lo <= 1'b0;
      got_hi <= 1'b0;
    end else if (rd_live) begin
      got_lo <= got_lo | ~half_sel;
      got_hi <= got_hi | half_sel;
    end
  end
endmodule

// File: rtl/rxl_bus.sv
module rxl_bus
  import rxl_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic [NCH*WORD_W-1:0] words,
  input  logic [NCH-1:0]        gnt,
  input  logic                  half_sel,
  output half_t                 bus_q
);
  half_t part [NCH];

  for (genvar c = 0; c < NCH; c++) begin : g_part
    assign part[c] = gnt[c] ? half_of(words[c*WORD_W +: WORD_W], half_sel) : '0;
  end

  always_comb begin
    bus_q = '0;
    for (int c = 0; c < NCH; c++) bus_q = bus_q | part[c];
  end
endmodule

// File: rtl/arinc_word_readout.sv
module arinc_word_readout
  import rxl_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NCH-1:0]        eos,
  input  logic [NCH*WORD_W-1:0] rx_word,
  input  logic                  match_en,
  input  logic [NCH*LBL_W-1:0]  match_bits,
  input  logic [NCH-1:0]        rd_stb,
  input  logic                  half_sel,
  output logic [NCH-1:0]        rdy_n,
  output logic [HALF_W-1:0]     bus_q,
  output logic                  bus_oe
);
  logic [NCH-1:0]        gnt;
  logic [NCH-1:0]        acc_evt;
  logic [NCH-1:0]        done_evt;
  logic [NCH*WORD_W-1:0] words;

  rxl_grant #(.NCH(NCH)) u_grant (
    .req (rd_stb),
    .gnt (gnt),
    .any (bus_oe)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    rxl_chan u_chan (
      .clk        (clk),
      .rst_n      (rst_n),
      .eos        (eos[c]),
      .word_in    (rx_word[c*WORD_W +: WORD_W]),
      .match_en   (match_en),
      .match_bits (match_bits[c*LBL_W +: LBL_W]),
      .rd_grant   (gnt[c]),
      .half_sel   (half_sel),
      .word_q     (words[c*WORD_W +: WORD_W]),
      .rdy_n      (rdy_n[c]),
      .acc_evt    (acc_evt[c]),
      .done_evt   (done_evt[c])
    );
  end

  rxl_bus #(.NCH(NCH)) u_bus (
    .words    (words),
    .gnt      (gnt),
    .half_sel (half_sel),
    .bus_q    (bus_q)
  );
endmodule

// File: rtl/rxl_checker.sv
module rxl_checker
  import rxl_pkg::*;
#(
  parameter int NCH = 2
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NCH-1:0]        eos,
  input logic [NCH*WORD_W-1:0] rx_word,
  input logic                  match_en,
  input logic [NCH*LBL_W-1:0]  match_bits,
  input logic [NCH-1:0]        rd_stb,
  input logic [NCH-1:0]        rdy_n,
  input logic [HALF_W-1:0]     bus_q,
  input logic                  bus_oe,
  input logic [NCH-1:0]        acc_evt,
  input logic [NCH-1:0]        done_evt
);
  AST_BUS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb == '0) |-> (bus_q == '0 && !bus_oe)); // R9
  AST_OE_ON_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb != '0) |-> bus_oe); // R9

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    AST_RDY_ON_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      acc_evt[c] |=> !rdy_n[c]); // R2
    AST_REJECT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (eos[c] && match_en && rdy_n[c] &&
       rx_word[c*WORD_W+LBL_LSB +: LBL_W] != match_bits[c*LBL_W +: LBL_W]) |=> rdy_n[c]); // R3
    AST_NOFILTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
      (eos[c] && !match_en) |-> acc_evt[c]); // R4
    AST_HOLD_WITHOUT_READ: assert property (@(posedge clk) disable iff (!rst_n)
      (!rdy_n[c] && !rd_stb[c]) |=> !rdy_n[c]); // R6
    AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
      done_evt[c] |=> rdy_n[c]); // R6
    AST_ARRIVAL_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_evt[c] && rd_stb[c]) |=> !rdy_n[c]); // R11
    AST_IDLE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      (rdy_n[c] && !eos[c]) |=> rdy_n[c]); // R8
  end
endmodule

bind arinc_word_readout rxl_checker #(.NCH(NCH)) u_rxl_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .eos        (eos),
  .rx_word    (rx_word),
  .match_en   (match_en),
  .match_bits (match_bits),
  .rd_stb     (rd_stb),
  .rdy_n      (rdy_n),
  .bus_q      (bus_q),
  .bus_oe     (bus_oe),
  .acc_evt    (acc_evt),
  .done_evt   (done_evt)
);

// File: tb/arinc_word_readout_tb.sv
module arinc_word_readout_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  eos = '0;
  logic [63:0] rx_word = '0;
  logic        match_en = 1'b0;
  logic [3:0]  match_bits = '0;
  logic [1:0]  rd_stb = '0;
  logic        half_sel = 1'b0;
  logic [1:0]  rdy_n;
  logic [15:0] bus_q;
  logic        bus_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] m_word [2];
  bit          m_rdy [2];
  bit          m_lo [2];
  bit          m_hi [2];

  always #4 clk = ~clk;

  arinc_word_readout dut_i (
    .clk(clk), .rst_n(rst_n), .eos(eos), .rx_word(rx_word), .match_en(match_en),
    .match_bits(match_bits), .rd_stb(rd_stb), .half_sel(half_sel),
    .rdy_n(rdy_n), .bus_q(bus_q), .bus_oe(bus_oe)
  );

  function automatic bit f_accept(logic [31:0] w, logic en, logic [1:0] lbl);
    if (!en) return 1'b1;
    return (w[9] == lbl[1]) && (w[8] == lbl[0]);
  endfunction

  function automatic logic [15:0] f_half(logic [31:0] w, logic upper);
    logic [31:0] sh;
    sh = upper ? (w >> 16) : w;
    return sh[15:0];
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // One cycle: inputs already set after a falling edge.
  task automatic cyc(string tag);
    logic [15:0] exp_bus;
    int g;
    bit acc, upd;
    #1;
    g = rd_stb[0] ? 0 : (rd_stb[1] ? 1 : -1);
    exp_bus = (g < 0) ? 16'h0 : f_half(m_word[g], half_sel);
    check(bus_q === exp_bus, {tag, " R5 R10 bus"}, 32'(bus_q), 32'(exp_bus));
    check(bus_oe === (g >= 0), {tag, " R9 oe"}, 32'(bus_oe), 32'(g >= 0));
    @(posedge clk);
    for (int c = 0; c < 2; c++) begin
      acc = eos[c] && f_accept(rx_word[c*32 +: 32], match_en, match_bits[c*2 +: 2]);
      upd = (g == c) && m_rdy[c];
      if (acc) begin
        m_word[c] = rx_word[c*32 +: 32];
        m_rdy[c] = 1; m_lo[c] = 0; m_hi[c] = 0;
      end else if (upd) begin
        if ((half_sel && m_lo[c]) || (!half_sel && m_hi[c])) begin
          m_rdy[c] = 0; m_lo[c] = 0; m_hi[c] = 0;
        end else if (half_sel) m_hi[c] = 1;
        else m_lo[c] = 1;
      end
    end
    @(negedge clk);
    for (int c = 0; c < 2; c++)
      check(rdy_n[c] === !m_rdy[c], {tag, " R2 R6 R8 rdy"}, 32'(rdy_n[c]), 32'(!m_rdy[c]));
    eos = '0; rd_stb = '0;
  endtask

  task automatic arrive(int c, logic [31:0] w, string tag);
    eos[c] = 1'b1; rx_word[c*32 +: 32] = w; cyc(tag);
  endtask

  task automatic rd(int c, logic s, string tag);
    rd_stb[c] = 1'b1; half_sel = s; cyc(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    for (int c = 0; c < 2; c++) begin m_word[c] = 0; m_rdy[c] = 0; m_lo[c] = 0; m_hi[c] = 0; end
    repeat (3) @(negedge clk);
    check(rdy_n === 2'b11, "R1 rdy", 32'(rdy_n), 32'h3);
    check(bus_q === 16'h0 && bus_oe === 1'b0, "R1 bus", 32'(bus_q), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    rd(0, 1'b0, "R1 word0 lo");
    // R4: filter off accepts anything
    arrive(0, 32'hDEAD_BEEF, "R4");
    // R5 R6: low then high
    rd(0, 1'b0, "R5 lo"); rd(0, 1'b0, "R6 repeat lo"); rd(0, 1'b1, "R6 complete");
    // R12: read while idle keeps tracking untouched
    rd(0, 1'b1, "R12 idle read");
    arrive(0, 32'h1234_5678, "R2");
    rd(0, 1'b1, "R6 hi first"); rd(0, 1'b0, "R6 lo second");
    // R3: filter on, mismatch then match (bits[9:8]=01 vs 10)
    match_en = 1'b1; match_bits = 4'b1010;
    arrive(1, 32'h0000_0100, "R3 reject");
    rd(1, 1'b0, "R3 word kept");
    arrive(1, 32'hA5A5_02C3, "R3 accept");
    rd(1, 1'b1, "R3 hi");
    // R7: overwrite between halves resets tracking
    arrive(1, 32'h0F0F_0200, "R7 overwrite");
    rd(1, 1'b0, "R7 lo again"); rd(1, 1'b1, "R7 done");
    // R10: both strobes, channel 0 wins
    match_en = 1'b0;
    arrive(0, 32'h1111_2222, "R10 load0"); arrive(1, 32'h3333_4444, "R10 load1");
    rd_stb = 2'b11; half_sel = 1'b0; cyc("R10 both lo");
    rd_stb = 2'b11; half_sel = 1'b1; cyc("R10 both hi");
    // R8: channel 1 unaffected, still ready
    rd(1, 1'b1, "R8 ch1 hi"); rd(1, 1'b0, "R8 ch1 lo");
    // R11: arrival coincides with completing read
    arrive(0, 32'h5555_6666, "R11 load");
    rd(0, 1'b0, "R11 lo");
    eos[0] = 1'b1; rx_word[31:0] = 32'h7777_8888; rd_stb[0] = 1'b1; half_sel = 1'b1; cyc("R11 clash");
    rd(0, 1'b1, "R11 hi after"); rd(0, 1'b0, "R11 lo after");
    // Random phase
    for (int i = 0; i < 3000; i++) begin
      eos = 2'($urandom_range(0, 3)) & {$urandom_range(0, 2) == 0, $urandom_range(0, 2) == 0};
      rx_word = {$urandom, $urandom};
      match_en = ($urandom_range(0, 1) == 1);
      match_bits = 4'($urandom);
      rd_stb = 2'($urandom);
      half_sel = $urandom_range(0, 1) == 1;
      cyc("R2 R3 R6 R7 random");
    end
    finish_run();
  end

  initial begin
    void'($urandom(32'h5EED_0429));
  end
endmodule